// File: doc/BRIEF.md
# DMA Bus Hold Limiter

This block limits how long a high-priority DMA engine may keep the system bus within one session. Software writes an 8-bit control word that carries an enable flag and a 7-bit budget. The budget is counted in units of 256 system clocks.

A session starts on the first clock edge that sees the DMA request and the bus grant both high. From that edge the block counts prescaled units. If the count reaches the budget while the session is still open, the block raises a one-cycle abort request, and the DMA engine must then give the bus back.

The session closes when either the request or the grant drops. Closing a session clears all counting state. Enable and budget are captured when a session opens, so a write made during a session does not change the limit that session is held to.

Top module: `bus_hold_limiter`

## Requirements
- R1: After reset, `cfg_rdata` reads 0x00 and `dma_abort` is low.
- R2: A write whose bits 6:0 are nonzero stores the whole byte. Bit 7 is the enable flag (1 = limit active) and bits 6:0 are the budget N. `cfg_rdata` returns exactly the stored byte from the cycle after the write edge.
- R3: A write whose bits 6:0 are zero is ignored entirely, bit 7 included, and `cfg_rdata` keeps its previous value.
- R4: Let edge E0 be the first rising edge at which `dma_req` and `bus_grant` are both high, with the limit enabled and budget N (1 to 127). `dma_abort` is high only during the clock cycle that follows rising edge E0 + 256·N, provided the session stays open.
- R5: The abort is a single-cycle pulse. While the same session stays open, no further pulse occurs, however long the bus is held.
- R6: When the enable flag captured at session start is 0, `dma_abort` never rises during that session.
- R7: Closing a session before the budget is used up discards the partial count. The next session is again timed the full 256·N cycles from its own E0.
- R8: A configuration write during an open session does not change that session's limit. The new budget applies from the next session onward.
- R9: Dropping `dma_req` while `bus_grant` stays high closes the session, exactly as dropping the grant does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Write strobe for the control byte |
| cfg_wdata | input | 8 | Control byte to write: bit 7 enable, bits 6:0 budget |
| cfg_rdata | output | 8 | Stored control byte |
| dma_req | input | 1 | DMA engine is requesting the bus |
| bus_grant | input | 1 | Bus is granted to the DMA engine |
| dma_abort | output | 1 | One-cycle request to end the DMA session |

## Verification
The bench places the abort edge exactly at 256·N cycles for budgets 1, 2, 3 and the maximum of 127. A design that is off by one prescaler unit, or by one register stage, would abort a cycle early, a cycle late, or a whole unit late.

It holds the bus long after an abort, and a design that failed to re-arm correctly would pulse again every time its counter wrapped. It closes a session partway through, both by dropping the grant and by dropping only the request. A design that kept the partial count would abort the following session too early.

It also writes a zero budget, which a careless register would store as a dead limit. It rewrites the budget during an open session, which a design comparing against the live register would honour at once.

// File: rtl/bhl_pkg.sv
package bhl_pkg;

   // Session state of the occupancy timer
   typedef enum logic [1:0] {
      BHL_IDLE  = 2'd0,   // bus not held by the DMA
      BHL_COUNT = 2'd1,   // held, limit active, counting units
      BHL_FREE  = 2'd2,   // held, limit disabled for this session
      BHL_SPENT = 2'd3    // held, abort already issued
   } bhl_state_t;

   // Number of system clocks in one budget unit for a prescaler width
   function automatic int unsigned bhl_unit_clocks(input int unsigned pre_w);
      return 32'd1 << pre_w;
   endfunction

endpackage

// File: rtl/bhl_ctrl_reg.sv
module bhl_ctrl_reg #(
   parameter int unsigned CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CNT_W:0]   wdata,
   output logic             en_o,
   output logic [CNT_W-1:0] bud_o,
   output logic [CNT_W:0]   rdata_o
);

   localparam int unsigned REG_W = CNT_W + 1;

   generate
      if (CNT_W < 2 || CNT_W > 16) begin : g_bad_cnt_w
         $error("bhl_ctrl_reg: CNT_W must be within 2..16");
      end
   endgenerate

   logic [REG_W-1:0] reg_q;
   logic             wr_ok;

   // A write is accepted only when its budget field is nonzero
   assign wr_ok = wr_en && (wdata[CNT_W-1:0] != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_q <= '0;
      end else if (wr_ok) begin
         reg_q <= wdata;
      end
   end

   assign en_o    = reg_q[CNT_W];
   assign bud_o   = reg_q[CNT_W-1:0];
   assign rdata_o = reg_q;

   // R3
   zero_write_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wdata[CNT_W-1:0] == '0) |=> $stable(rdata_o));

   // R2
   write_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wdata[CNT_W-1:0] != '0) |=> (rdata_o == $past(wdata)));

endmodule

// File: rtl/bhl_prescaler.sv
module bhl_prescaler #(
   parameter int unsigned PRE_W = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic run,
   output logic tick_o
);

   generate
      if (PRE_W < 1 || PRE_W > 16) begin : g_bad_pre_w
         $error("bhl_prescaler: PRE_W must be within 1..16");
      end

      if (PRE_W == 1) begin : g_toggle
         // Divide by two: a single phase flop
         logic ph_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ph_q <= 1'b0;
            end else if (clr) begin
               ph_q <= 1'b0;
            end else if (run) begin
               ph_q <= ~ph_q;
            end
         end
         assign tick_o = run && !clr && ph_q;

         // R7
         pre_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            clr |=> !ph_q);
      end else begin : g_counter
         // Divide by 2**PRE_W: wrapping binary counter
         logic [PRE_W-1:0] pre_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pre_q <= '0;
            end else if (clr) begin
               pre_q <= '0;
            end else if (run) begin
               pre_q <= pre_q + PRE_W'(1);
            end
         end
         assign tick_o = run && !clr && (&pre_q);

         // R7
         pre_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            clr |=> (pre_q == '0));

         // R4
         pre_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (run && !clr) |=> (pre_q == $past(pre_q) + PRE_W'(1)));
      end
   endgenerate

endmodule

// File: rtl/bhl_budget_fsm.sv
module bhl_budget_fsm
   import bhl_pkg::*;
#(
   parameter int unsigned CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             tick,
   input  logic             en_in,
   input  logic [CNT_W-1:0] bud_in,
   output logic             pre_run_o,
   output logic             pre_clr_o,
   output logic             term_o
);

   generate
      if (CNT_W < 2 || CNT_W > 16) begin : g_bad_cnt_w
         $error("bhl_budget_fsm: CNT_W must be within 2..16");
      end
   endgenerate

   bhl_state_t       state_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nxt;
   logic [CNT_W-1:0] bud_lat_q;
   logic             en_lat_q;
   logic             term_q;
   logic             last_unit;

   assign cnt_nxt   = cnt_q + CNT_W'(1);
   assign last_unit = (cnt_nxt == bud_lat_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= BHL_IDLE;
         cnt_q     <= '0;
         bud_lat_q <= '0;
         en_lat_q  <= 1'b0;
         term_q    <= 1'b0;
      end else begin
         term_q <= 1'b0;
         if (!active) begin
            state_q <= BHL_IDLE;
            cnt_q   <= '0;
         end else begin
            unique case (state_q)
               BHL_IDLE: begin
                  // Capture the limit for the whole session
                  bud_lat_q <= bud_in;
                  en_lat_q  <= en_in;
                  cnt_q     <= '0;
                  state_q   <= en_in ? BHL_COUNT : BHL_FREE;
               end
               BHL_COUNT: begin
                  if (tick) begin
                     cnt_q <= cnt_nxt;
                     if (last_unit) begin
                        term_q  <= 1'b1;
                        state_q <= BHL_SPENT;
                     end
                  end
               end
               BHL_FREE:  state_q <= BHL_FREE;
               BHL_SPENT: state_q <= BHL_SPENT;
               default:   state_q <= BHL_IDLE;
            endcase
         end
      end
   end

   assign pre_run_o = active && (state_q == BHL_COUNT);
   assign pre_clr_o = !pre_run_o;
   assign term_o    = term_q;

   // R5
   term_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      term_q |=> !term_q);

   // R6
   term_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      term_q |-> en_lat_q);

   // R5
   spent_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == BHL_SPENT) |=> !term_q);

   // R7
   release_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> (state_q == BHL_IDLE && cnt_q == '0 && !term_q));

   // R8
   budget_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && state_q != BHL_IDLE) |=> $stable(bud_lat_q));

   // R4
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == BHL_COUNT) |-> (cnt_q < bud_lat_q));

endmodule

// File: rtl/bus_hold_limiter.sv
module bus_hold_limiter #(
   parameter int unsigned CNT_W = 7,
   parameter int unsigned PRE_W = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cfg_wr,
   input  logic [CNT_W:0] cfg_wdata,
   output logic [CNT_W:0] cfg_rdata,
   input  logic           dma_req,
   input  logic           bus_grant,
   output logic           dma_abort
);

   logic             en_w;
   logic [CNT_W-1:0] bud_w;
   logic             active_w;
   logic             tick_w;
   logic             pre_run_w;
   logic             pre_clr_w;

   // A session is open only while both request and grant are high
   assign active_w = dma_req && bus_grant;

   bhl_ctrl_reg #(.CNT_W(CNT_W)) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_wr),
      .wdata   (cfg_wdata),
      .en_o    (en_w),
      .bud_o   (bud_w),
      .rdata_o (cfg_rdata)
   );

   bhl_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (pre_clr_w),
      .run    (pre_run_w),
      .tick_o (tick_w)
   );

   bhl_budget_fsm #(.CNT_W(CNT_W)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (active_w),
      .tick      (tick_w),
      .en_in     (en_w),
      .bud_in    (bud_w),
      .pre_run_o (pre_run_w),
      .pre_clr_o (pre_clr_w),
      .term_o    (dma_abort)
   );

   // R6
   abort_in_session_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dma_abort |-> $past(active_w));

endmodule

// File: tb/bus_hold_limiter_tb.sv
module bus_hold_limiter_tb;

   localparam int UNIT = 256;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_wr = 1'b0;
   logic [7:0] cfg_wdata = '0;
   logic [7:0] cfg_rdata;
   logic       dma_req = 1'b0;
   logic       bus_grant = 1'b0;
   logic       dma_abort;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   bus_hold_limiter u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_wr    (cfg_wr),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .dma_req   (dma_req),
      .bus_grant (bus_grant),
      .dma_abort (dma_abort)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr_cfg(input logic [7:0] v);
      @(negedge clk);
      cfg_wr = 1'b1;
      cfg_wdata = v;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic release_bus();
      @(negedge clk);
      dma_req = 1'b0;
      bus_grant = 1'b0;
      @(negedge clk);
      @(negedge clk);
   endtask

   // Open a session at a negedge, then watch ncyc negedges.
   // Index i is the negedge after posedge number i, with posedge 1 being E0.
   task automatic watch(input int ncyc, output int first, output int pulses);
      first = -1;
      pulses = 0;
      dma_req = 1'b1;
      bus_grant = 1'b1;
      for (int i = 1; i <= ncyc; i++) begin
         @(negedge clk);
         if (dma_abort) begin
            pulses++;
            if (first < 0) first = i;
         end
      end
   endtask

   task automatic t_reset();
      chk(cfg_rdata == 8'h00, "R1 rdata", cfg_rdata, 0);
      chk(dma_abort == 1'b0, "R1 abort", dma_abort, 0);
   endtask

   task automatic t_regrw();
      wr_cfg(8'hA5);
      chk(cfg_rdata == 8'hA5, "R2 readback A5", cfg_rdata, 8'hA5);
      wr_cfg(8'h01);
      chk(cfg_rdata == 8'h01, "R2 readback 01", cfg_rdata, 8'h01);
   endtask

   task automatic t_zero_write();
      wr_cfg(8'h83);
      wr_cfg(8'h80);
      chk(cfg_rdata == 8'h83, "R3 zero budget with enable", cfg_rdata, 8'h83);
      wr_cfg(8'h00);
      chk(cfg_rdata == 8'h83, "R3 all zero", cfg_rdata, 8'h83);
   endtask

   task automatic t_budget(input int n);
      int f, p;
      wr_cfg(8'h80 | n[7:0]);
      watch(UNIT * n + 4, f, p);
      chk(f == UNIT * n + 1, $sformatf("R4 abort time N=%0d", n), f, UNIT * n + 1);
      chk(p == 1, $sformatf("R5 pulse count N=%0d", n), p, 1);
      release_bus();
   endtask

   task automatic t_hold_after();
      int f, p;
      wr_cfg(8'h81);
      watch(UNIT * 6, f, p);
      chk(f == UNIT + 1, "R5 first abort", f, UNIT + 1);
      chk(p == 1, "R5 no repeat while held", p, 1);
      release_bus();
      watch(UNIT + 4, f, p);
      chk(f == UNIT + 1, "R5 new session aborts again", f, UNIT + 1);
      release_bus();
   endtask

   task automatic t_disabled();
      int f, p;
      wr_cfg(8'h01);
      watch(UNIT * 4, f, p);
      chk(p == 0, "R6 disabled never aborts", p, 0);
      release_bus();
   endtask

   task automatic t_early_release();
      int f, p;
      wr_cfg(8'h82);
      watch(UNIT + 100, f, p);
      chk(p == 0, "R7 no abort before release", p, 0);
      release_bus();
      watch(UNIT * 2 + 4, f, p);
      chk(f == UNIT * 2 + 1, "R7 full budget after release", f, UNIT * 2 + 1);
      release_bus();
   endtask

   task automatic t_midchange();
      int f;
      f = -1;
      wr_cfg(8'h82);
      dma_req = 1'b1;
      bus_grant = 1'b1;
      for (int i = 1; i <= UNIT * 2 + 4; i++) begin
         @(negedge clk);
         cfg_wr = (i == 100);
         cfg_wdata = 8'h81;
         if (dma_abort && f < 0) f = i;
      end
      cfg_wr = 1'b0;
      chk(f == UNIT * 2 + 1, "R8 latched budget used", f, UNIT * 2 + 1);
      chk(cfg_rdata == 8'h81, "R8 write still stored", cfg_rdata, 8'h81);
      release_bus();
      begin
         int g, p;
         watch(UNIT + 4, g, p);
         chk(g == UNIT + 1, "R8 new budget next session", g, UNIT + 1);
      end
      release_bus();
   endtask

   task automatic t_req_drop();
      int f, p;
      wr_cfg(8'h82);
      watch(300, f, p);
      @(negedge clk);
      dma_req = 1'b0;          // grant stays high
      @(negedge clk);
      @(negedge clk);
      watch(UNIT * 2 + 4, f, p);
      chk(f == UNIT * 2 + 1, "R9 request drop restarts count", f, UNIT * 2 + 1);
      chk(p == 1, "R9 single pulse", p, 1);
      release_bus();
   endtask

   initial begin
      #1;
      chk(dma_abort == 1'b0, "R1 abort in reset", dma_abort, 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regrw();
      t_zero_write();
      t_budget(1);
      t_budget(3);
      t_budget(2);
      t_budget(127);
      t_hold_after();
      t_disabled();
      t_early_release();
      t_midchange();
      t_req_drop();
      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (150000) @(posedge clk);
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         end
      join_any
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule